// File: doc/BRIEF.md
# Playfield Tile Renderer with Duty-Cycle Shading

This block draws the playfield of a falling-block puzzle game into a VGA raster. The field is 10 cells wide and 20 cells tall. Its contents sit in a dual-port RAM. This block only reads from one port of that RAM; the game logic owns the other port and drives it independently. The raster generator supplies three things for each pixel: the pixel coordinates, a video-active flag and a pixel clock enable. From the coordinates the renderer works out which cell the pixel lies in and issues that cell's address to the RAM. When the cell word returns, the renderer decodes it into 1-bit red, green and blue outputs.

Each cell word is 4 bits wide. Bit 3 is the occupied flag and bits 2:0 are a colour code. On its own this gives only eight colours. More shades come from gating the colour channels with a free-running divider: its bit 0 runs at half the system clock rate, bit 1 at a quarter and bit 2 at an eighth. The renderer uses these bits for two effects:
- Occupied cells get a dimmer border one pixel wide.
- Empty cells show a faint grid.

Each cell is 16x16 pixels. The field starts at pixel (160, 80) of a 640x480 frame. Every pixel outside the field is black.

Top module: `field_renderer`

## Requirements
- R1: After a synchronous reset, red, grn and blu are low and the 3-bit shade divider is 0.
- R2: A pixel presented with vid_act low produces black (all three outputs low).
- R3: While the pixel lies in the field, cell_addr equals {row[4:0], col[4:0]}, where row = (px_y-80)/16 and col = (px_x-160)/16. The address is combinational from the coordinates, so the RAM can read it one pixel clock before the colour is decoded.
- R4: A pixel with px_x < 160, px_x >= 320, px_y < 80 or px_y >= 400 produces black.
- R5: An interior pixel of an occupied cell (cell_word[3]=1) shows the palette colour at full duty. The colour codes map to {red,grn,blu} as follows: 0 black 000, 1 red 100, 2 green 010, 3 blue 001, 4 yellow 110, 5 aqua 011, 6 fuchsia 101, 7 white 111.
- R6: A pixel whose offset within its cell is 0 or 15 in either axis is an edge pixel. For an edge pixel of an occupied cell, each palette channel is ANDed with divider bit 0, which gives a 50% duty.
- R7: In an empty cell (cell_word[3]=0), edge pixels drive all three channels high only when the divider equals 7, which gives a 1/8 duty. Interior pixels of an empty cell are black.
- R8: Latency. Inputs presented before pixel-enabled clock edge k are registered at edge k, and cell_word is sampled at that same edge. The colour appears on the outputs after edge k+1, shaded with the divider value held just before edge k+1.
- R9: While pix_en is low, the registered pixel state and the sampled cell word are held, so the outputs keep showing the same pixel.
- R10: The shade divider counts up by one on every clock after reset and wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel clock enable |
| vid_act | input | 1 | Raster is in the visible area |
| px_x | input | 10 | Current pixel column |
| px_y | input | 10 | Current pixel row |
| cell_addr | output | 10 | Read address to the playfield RAM, {row, col} |
| cell_word | input | 4 | Synchronous read data from the playfield RAM |
| red | output | 1 | Red channel |
| grn | output | 1 | Green channel |
| blu | output | 1 | Blue channel |

## Verification
The bench sweeps a raster window 180 pixels wide and 332 lines tall. The window covers the whole field plus a margin on every side. The RAM is filled with a pattern that varies from cell to cell, so it contains every colour code in both the occupied and the empty state. Each pixel's colour is checked against a divider model in the bench.

The blanking pattern is set so vid_act falls at scattered positions, including inside the field; this separates blanking from out-of-field black. Sweeping every pixel of a cell separates edge pixels from interior pixels on all four sides. Because the divider phase changes from pixel to pixel, the sweep also exposes the 50% and 1/8 duties.

A final sequence lowers pix_en while the raster inputs point elsewhere. The outputs must keep showing a full-duty red pixel, which shows the pipeline holds its state.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef logic [2:0] rgb_t;  // {red, grn, blu}

  function automatic rgb_t pal_rgb(input logic [2:0] code);
    rgb_t c;
    case (code)
      3'd0:    c = 3'b000;
      3'd1:    c = 3'b100;
      3'd2:    c = 3'b010;
      3'd3:    c = 3'b001;
      3'd4:    c = 3'b110;
      3'd5:    c = 3'b011;
      3'd6:    c = 3'b101;
      default: c = 3'b111;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fr_pwm_div.sv
module fr_pwm_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DIV_W-1:0] div
);

  always_ff @(posedge clk) begin
    if (rst) div <= '0;
    else     div <= div + 1'b1;
  end

  // R10: free-running, one step per clock
  a_r10_div_steps: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> div == $past(div) + 1'b1)
    else $error("divider did not step");

endmodule

// File: rtl/fr_addr_gen.sv
module fr_addr_gen #(
  parameter int COLS      = 10,
  parameter int ROWS      = 20,
  parameter int CELL_LOG2 = 4,
  parameter int ORG_X     = 160,
  parameter int ORG_Y     = 80,
  parameter int COORD_W   = 10,
  parameter int COL_AW    = 5,
  parameter int ROW_AW    = 5
) (
  input  logic [COORD_W-1:0]       px_x,
  input  logic [COORD_W-1:0]       px_y,
  output logic                     hit,
  output logic                     on_edge,
  output logic [ROW_AW+COL_AW-1:0] addr
);

  localparam int FIELD_W = COLS << CELL_LOG2;
  localparam int FIELD_H = ROWS << CELL_LOG2;
  localparam int DXW     = CELL_LOG2 + COL_AW;
  localparam int DYW     = CELL_LOG2 + ROW_AW;

  logic [DXW-1:0]       dx;
  logic [DYW-1:0]       dy;
  logic [CELL_LOG2-1:0] lx, ly;
  logic                 in_x, in_y;

  assign in_x = (px_x >= COORD_W'(ORG_X)) && (px_x < COORD_W'(ORG_X + FIELD_W));
  assign in_y = (px_y >= COORD_W'(ORG_Y)) && (px_y < COORD_W'(ORG_Y + FIELD_H));
  assign hit  = in_x && in_y;

  assign dx = DXW'(px_x - COORD_W'(ORG_X));
  assign dy = DYW'(px_y - COORD_W'(ORG_Y));
  assign lx = dx[CELL_LOG2-1:0];
  assign ly = dy[CELL_LOG2-1:0];

  assign addr    = {dy[DYW-1:CELL_LOG2], dx[DXW-1:CELL_LOG2]};
  assign on_edge = (lx == '0) || (&lx) || (ly == '0) || (&ly);

  // R3: an in-field address never names a cell beyond the grid
  always_comb begin
    if (hit) begin
      a_r3_col_in_range: assert (addr[COL_AW-1:0] < COL_AW'(COLS))
        else $error("column out of range");
      a_r3_row_in_range: assert (addr[ROW_AW+COL_AW-1:COL_AW] < ROW_AW'(ROWS))
        else $error("row out of range");
    end
  end

endmodule

// File: rtl/fr_shader.sv
module fr_shader
  import fr_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             act,
  input  logic             hit,
  input  logic             on_edge,
  input  logic [3:0]       word,
  input  logic [DIV_W-1:0] div,
  output rgb_t             rgb
);

  logic half_on, dim_on;
  rgb_t base;

  assign half_on = div[0];
  assign dim_on  = &div;
  assign base    = pal_rgb(word[2:0]);

  always_comb begin
    if (!act || !hit)   rgb = 3'b000;
    else if (word[3])   rgb = on_edge ? (base & {3{half_on}}) : base;
    else                rgb = on_edge ? {3{dim_on}} : 3'b000;
  end

endmodule

// File: rtl/field_renderer.sv
module field_renderer
  import fr_pkg::*;
#(
  parameter int COLS      = 10,
  parameter int ROWS      = 20,
  parameter int CELL_LOG2 = 4,
  parameter int ORG_X     = 160,
  parameter int ORG_Y     = 80,
  parameter int COORD_W   = 10,
  parameter int COL_AW    = 5,
  parameter int ROW_AW    = 5,
  parameter int DIV_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pix_en,
  input  logic                     vid_act,
  input  logic [COORD_W-1:0]       px_x,
  input  logic [COORD_W-1:0]       px_y,
  output logic [ROW_AW+COL_AW-1:0] cell_addr,
  input  logic [3:0]               cell_word,
  output logic                     red,
  output logic                     grn,
  output logic                     blu
);

  logic             hit_c, edge_c;
  logic             st_act, st_hit, st_edge;
  logic [DIV_W-1:0] div;
  rgb_t             rgb_c, rgb_q;

  fr_addr_gen #(
    .COLS(COLS), .ROWS(ROWS), .CELL_LOG2(CELL_LOG2),
    .ORG_X(ORG_X), .ORG_Y(ORG_Y), .COORD_W(COORD_W),
    .COL_AW(COL_AW), .ROW_AW(ROW_AW)
  ) u_addr (
    .px_x(px_x), .px_y(px_y),
    .hit(hit_c), .on_edge(edge_c), .addr(cell_addr)
  );

  fr_pwm_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div(div)
  );

  // stage 1: pixel attributes aligned with the RAM read data
  always_ff @(posedge clk) begin
    if (rst) begin
      st_act  <= 1'b0;
      st_hit  <= 1'b0;
      st_edge <= 1'b0;
    end else if (pix_en) begin
      st_act  <= vid_act;
      st_hit  <= hit_c;
      st_edge <= edge_c;
    end
  end

  fr_shader #(.DIV_W(DIV_W)) u_shade (
    .act(st_act), .hit(st_hit), .on_edge(st_edge),
    .word(cell_word), .div(div), .rgb(rgb_c)
  );

  // stage 2: registered colour, refreshed every clock for the duty gating
  always_ff @(posedge clk) begin
    if (rst) rgb_q <= 3'b000;
    else     rgb_q <= rgb_c;
  end

  assign {red, grn, blu} = rgb_q;

  // R2: blanked pixel yields black on the following clock
  a_r2_dark_when_idle: assert property (@(posedge clk) disable iff (rst)
    !st_act |=> rgb_q == 3'b000)
    else $error("blanked pixel not black");

  // R4: pixel outside the field yields black
  a_r4_dark_outside: assert property (@(posedge clk) disable iff (rst)
    !st_hit |=> rgb_q == 3'b000)
    else $error("out-of-field pixel not black");

  // R5: occupied interior pixel shows its palette colour
  a_r5_full_colour: assert property (@(posedge clk) disable iff (rst)
    (st_act && st_hit && cell_word[3] && !st_edge) |=> rgb_q == pal_rgb($past(cell_word[2:0])))
    else $error("interior colour wrong");

  // R6: occupied edge pixel is dark while the half-rate bit is low
  a_r6_edge_half: assert property (@(posedge clk) disable iff (rst)
    (st_act && st_hit && cell_word[3] && st_edge && !div[0]) |=> rgb_q == 3'b000)
    else $error("edge pixel lit in off phase");

  // R9: pipeline holds while the pixel enable is low
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable({st_act, st_hit, st_edge}))
    else $error("stage changed without pixel enable");

endmodule

// File: tb/field_renderer_tb.sv
module field_renderer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_en = 1'b1;
  logic       vid_act = 1'b0;
  logic [9:0] px_x = '0, px_y = '0;
  logic [9:0] cell_addr;
  logic [3:0] cell_word;
  logic       red, grn, blu;

  logic [3:0] mem [0:1023];
  logic [2:0] bdiv;

  int n_chk = 0, n_bad = 0;

  // pixel history: h1 registered at the last edge, h2 at the one before
  int h1x, h1y, h2x, h2y;
  logic h1a, h2a, hv1, hv2;

  always #2.5 clk = ~clk;

  field_renderer u_dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .vid_act(vid_act),
    .px_x(px_x), .px_y(px_y), .cell_addr(cell_addr), .cell_word(cell_word),
    .red(red), .grn(grn), .blu(blu)
  );

  // synchronous-read RAM model on the renderer's port
  always @(posedge clk) if (pix_en) cell_word <= mem[cell_addr];

  // divider model (R10)
  always @(posedge clk) begin
    if (rst) bdiv <= 3'd0;
    else     bdiv <= bdiv + 3'd1;
  end

  function automatic logic [2:0] pal(input logic [2:0] c);
    case (c)
      3'd0: pal = 3'b000; 3'd1: pal = 3'b100; 3'd2: pal = 3'b010; 3'd3: pal = 3'b001;
      3'd4: pal = 3'b110; 3'd5: pal = 3'b011; 3'd6: pal = 3'b101; default: pal = 3'b111;
    endcase
  endfunction

  function automatic bit in_field(input int x, input int y);
    return x >= 160 && x < 320 && y >= 80 && y < 400;
  endfunction

  function automatic logic [2:0] expect_rgb(input int x, input int y, input logic a,
                                            input logic [2:0] d);
    int lx, ly;
    logic [3:0] w;
    bit e;
    if (!a || !in_field(x, y)) return 3'b000;
    lx = (x - 160) % 16;
    ly = (y - 80) % 16;
    w  = mem[((y - 80) / 16) * 32 + (x - 160) / 16];
    e  = (lx == 0) || (lx == 15) || (ly == 0) || (ly == 15);
    if (w[3]) return e ? (pal(w[2:0]) & {3{d[0]}}) : pal(w[2:0]);
    return e ? {3{d == 3'd7}} : 3'b000;
  endfunction

  function automatic string tag_of(input int x, input int y, input logic a);
    if (!a) return "R2";
    if (!in_field(x, y)) return "R4";
    return "R5/R6/R7/R8";
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int x, input int y, input logic a);
    @(negedge clk);
    if (hv2)
      check(tag_of(h2x, h2y, h2a), {7'd0, red, grn, blu},
            {7'd0, expect_rgb(h2x, h2y, h2a, bdiv - 3'd1)});
    h2x = h1x; h2y = h1y; h2a = h1a; hv2 = hv1;
    h1x = x;   h1y = y;   h1a = a;   hv1 = 1'b1;
    px_x = 10'(x); px_y = 10'(y); vid_act = a;
    #1;
    if (in_field(x, y))  // R3
      check("R3", cell_addr, 10'((((y - 80) / 16) << 5) | ((x - 160) / 16)));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 4'((((i >> 5) * 7) + ((i & 31) * 3) + 1) % 16);
    mem[2 * 32 + 3] = 4'b1001;  // occupied red cell for the hold test
    hv1 = 1'b0; hv2 = 1'b0;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1", {7'd0, red, grn, blu}, 10'd0);
    check("R1", {7'd0, bdiv}, 10'd1);  // one clock after release

    // raster sweep covering the field and a margin on every side
    for (int y = 74; y < 406; y++)
      for (int x = 150; x < 330; x++)
        step(x, y, ((x + 3 * y) % 7) != 0);
    step(0, 0, 1'b0);
    step(0, 0, 1'b0);

    // R9: freeze on an interior red pixel while inputs move away
    hv1 = 1'b0; hv2 = 1'b0;
    step(160 + 3 * 16 + 5, 80 + 2 * 16 + 7, 1'b1);
    step(160 + 3 * 16 + 5, 80 + 2 * 16 + 7, 1'b1);
    @(negedge clk);
    pix_en = 1'b0; px_x = 10'd0; px_y = 10'd0; vid_act = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R9", {7'd0, red, grn, blu}, 10'b100);
    end
    pix_en = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule